// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Controller

This block is the digital controller of a two-port I2C buffer that joins a backplane-side bus to a card-side bus. It owns the single enable that links the two sides. It also owns two open-drain pull-down requests, one for the card-side SCL and one for the card-side SDA, and a fault flag. All line inputs are already-synchronised logic levels.

After reset the sides stay apart. Each side must first prove it is safe, either by staying idle for a while or by showing a STOP. Once both sides qualify, the link closes. While linked, the block keeps a separate low-time counter on the card-side SCL and on the card-side SDA.

When either line stays low too long, the block raises the fault flag and opens the link. It then clocks the card-side SCL to walk a hung slave out of its transfer, and stops early once SDA is seen released. It closes with a STOP and relinks. A rising edge on the enable input cuts recovery short and relinks at once. When the disconnect-enable input is low, a stuck line is only flagged and the link stays closed.

Top module: `i2c_stuck_recover`

## Requirements
- R1: Each card-side line has its own low-time counter. The link opens only when a single line has been sampled low on STUCK_CYCLES consecutive clocks, and connect_o falls right after the clock edge that takes that STUCK_CYCLES-th low sample.
- R2: A line sampled high clears its own counter. Lows on the two lines never add up, and a low stretch of STUCK_CYCLES-1 clocks leaves the link and the fault flag untouched.
- R3: On a timeout with disc_en_i high, connect_o goes low and fault_o goes high on the same edge.
- R4: Each recovery pulse holds cd_scl_pd_o high for HALF_PERIOD clocks and then low for HALF_PERIOD clocks. The first pulse starts on the timeout edge.
- R5: At the end of each pulse's released half, the block ends pulsing if card SDA reads high or if MAX_PULSES pulses are done. When SDA is freed during pulse k, exactly k pulses are produced.
- R6: The STOP runs in three phases of HALF_PERIOD clocks each. First both pull-downs are on. Then SCL is released while SDA is held. Then both are released with the link still open. connect_o rises on the next edge.
- R7: While linked with both card lines high, fault_o clears on the next edge.
- R8: After reset the link stays open until both sides qualify. A side qualifies when it has had both lines high for IDLE_CYCLES consecutive samples, or when its SDA was sampled rising while its SCL was high on both samples. The link closes one edge after the last side qualifies.
- R9: A rising edge on en_i during recovery returns the block to the linked state on that edge and drops both pull-downs.
- R10: With disc_en_i low, a timeout sets fault_o but connect_o stays high and neither pull-down is driven.
- R11: During reset connect_o, cd_scl_pd_o, cd_sda_pd_o and fault_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp_scl_i | input | 1 | Backplane-side SCL level |
| bp_sda_i | input | 1 | Backplane-side SDA level |
| cd_scl_i | input | 1 | Card-side SCL level |
| cd_sda_i | input | 1 | Card-side SDA level |
| en_i | input | 1 | Rising edge forces relink during recovery |
| disc_en_i | input | 1 | High allows a timeout to open the link |
| connect_o | output | 1 | Joins the two sides when high |
| cd_scl_pd_o | output | 1 | Request to pull card-side SCL low |
| cd_sda_pd_o | output | 1 | Request to pull card-side SDA low |
| fault_o | output | 1 | Stuck line detected, not yet cleared |

## Verification
The recovery sequence is driven against a model of a hung slave that frees SDA after a chosen number of SCL falling edges: 1, 3, 7, 15, 16, or never. These cases separate the early exit from the pulse cap, and they show whether the STOP appears only when SDA is actually free. Low stretches one clock short of the limit, alternated across the two lines or split by a single high sample, tell per-line counters apart from a shared timer. Startup is tried both with quiet buses and with buses held busy until a STOP, which shows that the two qualifying paths and the two sides are each honoured.

// File: rtl/i2c_stuck_recover.sv
module i2c_stuck_recover #(
  parameter int unsigned STUCK_CYCLES = 1_500_000,
  parameter int unsigned HALF_PERIOD  = 2941,
  parameter int unsigned IDLE_CYCLES  = 50,
  parameter int unsigned MAX_PULSES   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bp_scl_i,
  input  logic bp_sda_i,
  input  logic cd_scl_i,
  input  logic cd_sda_i,
  input  logic en_i,
  input  logic disc_en_i,
  output logic connect_o,
  output logic cd_scl_pd_o,
  output logic cd_sda_pd_o,
  output logic fault_o
);

  localparam int SW = $clog2(STUCK_CYCLES + 1);
  localparam int HW = $clog2(HALF_PERIOD + 1);
  localparam int IW = $clog2(IDLE_CYCLES + 1);
  localparam int PW = $clog2(MAX_PULSES + 1);

  typedef enum logic [2:0] {
    S_WAIT, S_LINK, S_PLOW, S_PHIGH, S_SLOW, S_SHOLD, S_SFREE
  } state_t;

  state_t        state;
  logic [HW-1:0] hc;
  logic [PW-1:0] pc;
  logic          en_q;
  logic [1:0]    trip;
  logic [1:0]    rdy;

  wire       linked  = (state == S_LINK);
  wire       en_rise = en_i & ~en_q;
  wire [1:0] mon_lo  = {~cd_scl_i, ~cd_sda_i};
  wire [1:0] side_scl = {cd_scl_i, bp_scl_i};
  wire [1:0] side_sda = {cd_sda_i, bp_sda_i};

  for (genvar i = 0; i < 2; i++) begin : g_mon
    logic [SW-1:0] lo_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      lo_cnt <= '0;
      else if (!linked || !mon_lo[i])  lo_cnt <= '0;
      else if (lo_cnt != SW'(STUCK_CYCLES)) lo_cnt <= lo_cnt + 1'b1;
    end
    assign trip[i] = linked && mon_lo[i] && (lo_cnt == SW'(STUCK_CYCLES - 1));
  end

  for (genvar i = 0; i < 2; i++) begin : g_side
    logic [IW-1:0] idle_cnt;
    logic          scl_q, sda_q;
    wire both_hi  = side_scl[i] & side_sda[i];
    wire stop_hit = ~sda_q & side_sda[i] & scl_q & side_scl[i];
    wire idle_hit = both_hi && (idle_cnt == IW'(IDLE_CYCLES - 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idle_cnt <= '0;
        scl_q    <= 1'b1;
        sda_q    <= 1'b1;
        rdy[i]   <= 1'b0;
      end else begin
        scl_q <= side_scl[i];
        sda_q <= side_sda[i];
        if (!both_hi)                              idle_cnt <= '0;
        else if (idle_cnt != IW'(IDLE_CYCLES - 1)) idle_cnt <= idle_cnt + 1'b1;
        if (state == S_WAIT && (stop_hit || idle_hit)) rdy[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_WAIT;
      hc      <= '0;
      pc      <= '0;
      fault_o <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      en_q <= en_i;
      case (state)
        S_WAIT: if (&rdy) state <= S_LINK;
        S_LINK: begin
          if (|trip) begin
            fault_o <= 1'b1;
            if (disc_en_i) begin
              state <= S_PLOW;
              hc    <= '0;
              pc    <= '0;
            end
          end else if (cd_scl_i && cd_sda_i) begin
            fault_o <= 1'b0;
          end
        end
        default: begin
          if (en_rise) begin
            state <= S_LINK;
            hc    <= '0;
          end else if (hc == HW'(HALF_PERIOD - 1)) begin
            hc <= '0;
            case (state)
              S_PLOW:  state <= S_PHIGH;
              S_PHIGH: begin
                if (cd_sda_i || pc == PW'(MAX_PULSES - 1)) state <= S_SLOW;
                else begin
                  state <= S_PLOW;
                  pc    <= pc + 1'b1;
                end
              end
              S_SLOW:  state <= S_SHOLD;
              S_SHOLD: state <= S_SFREE;
              default: state <= S_LINK;
            endcase
          end else begin
            hc <= hc + 1'b1;
          end
        end
      endcase
    end
  end

  assign connect_o   = linked;
  assign cd_scl_pd_o = (state == S_PLOW) || (state == S_SLOW);
  assign cd_sda_pd_o = (state == S_SLOW) || (state == S_SHOLD);

endmodule

// File: rtl/i2c_stuck_recover_chk.sv
module i2c_stuck_recover_chk #(
  parameter int unsigned MAX_PULSES = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cd_scl_i,
  input logic cd_sda_i,
  input logic en_i,
  input logic disc_en_i,
  input logic connect_o,
  input logic cd_scl_pd_o,
  input logic cd_sda_pd_o,
  input logic fault_o
);

  localparam int RW = $clog2(MAX_PULSES + 3) + 1;

  logic [RW-1:0] rises;
  logic          pd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises <= '0;
      pd_q  <= 1'b0;
    end else begin
      pd_q <= cd_scl_pd_o;
      if (connect_o)                 rises <= '0;
      else if (cd_scl_pd_o && !pd_q) rises <= rises + 1'b1;
    end
  end

  a_r1_quiet_keeps_link: assert property (@(posedge clk) disable iff (!rst_n)
    connect_o && cd_scl_i && cd_sda_i |=> connect_o);

  a_r3_drop_flags_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(connect_o) |-> fault_o);

  a_r5_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    rises <= RW'(MAX_PULSES + 1));

  a_r6_stop_shape: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cd_sda_pd_o) |-> !cd_scl_pd_o);

  a_r7_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o && connect_o && cd_scl_i && cd_sda_i |=> !fault_o);

  a_r9_force_relink: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_i) && (cd_scl_pd_o || cd_sda_pd_o) |=> connect_o);

  a_r10_hold_link: assert property (@(posedge clk) disable iff (!rst_n)
    connect_o && !disc_en_i |=> connect_o);

endmodule

bind i2c_stuck_recover i2c_stuck_recover_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cd_scl_i(cd_scl_i), .cd_sda_i(cd_sda_i),
  .en_i(en_i), .disc_en_i(disc_en_i), .connect_o(connect_o),
  .cd_scl_pd_o(cd_scl_pd_o), .cd_sda_pd_o(cd_sda_pd_o), .fault_o(fault_o)
);

// File: tb/i2c_stuck_recover_bench.sv
module i2c_stuck_recover_bench;
  localparam int STUCK = 40;
  localparam int H     = 4;
  localparam int IDLE  = 8;
  localparam int MAXP  = 16;

  localparam int VEC [0:5][0:2] = '{
    '{1, 1, 1}, '{3, 3, 1}, '{7, 7, 1}, '{15, 15, 1}, '{16, 16, 1}, '{0, 16, 0}
  };

  logic clk = 0, rst_n = 0;
  logic bx_scl = 1, bx_sda = 1, scl_hold = 0;
  logic en = 0, disc_en = 1, arm = 0;
  int   k = 0, base = 0, falls = 0, pdrises = 0, stops = 0;
  int   checks = 0, failures = 0;
  logic wd = 0;

  logic connect, scl_pd, sda_pd, fault;
  wire slv_low  = arm && (k == 0 || (falls - base) < k);
  wire bp_scl   = bx_scl & (connect ? ~scl_hold : 1'b1);
  wire bp_sda   = bx_sda & (connect ? ~slv_low : 1'b1);
  wire card_scl = ~scl_hold & ~scl_pd & (connect ? bx_scl : 1'b1);
  wire card_sda = ~slv_low & ~sda_pd & (connect ? bx_sda : 1'b1);

  i2c_stuck_recover #(.STUCK_CYCLES(STUCK), .HALF_PERIOD(H), .IDLE_CYCLES(IDLE),
                      .MAX_PULSES(MAXP)) u_i2c_stuck_recover (
    .clk(clk), .rst_n(rst_n), .bp_scl_i(bp_scl), .bp_sda_i(bp_sda),
    .cd_scl_i(card_scl), .cd_sda_i(card_sda), .en_i(en), .disc_en_i(disc_en),
    .connect_o(connect), .cd_scl_pd_o(scl_pd), .cd_sda_pd_o(sda_pd), .fault_o(fault));

  always #10 clk = ~clk;

  always @(negedge card_scl) falls++;
  always @(posedge scl_pd) pdrises++;
  always @(posedge card_sda) if (card_scl) stops++;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_conn(input logic lvl);
    for (int n = 0; n < 2000 && connect != lvl; n++) step(1);
  endtask

  task automatic run_all();
    int p0, s0;
    step(2);
    chk("R11 connect", connect, 0); chk("R11 scl_pd", scl_pd, 0);
    chk("R11 sda_pd", sda_pd, 0);   chk("R11 fault", fault, 0);
    rst_n = 1;
    step(IDLE);     chk("R8 idle early", connect, 0);
    step(1);        chk("R8 idle link", connect, 1);

    bx_sda = 0; step(STUCK - 1); bx_sda = 1;
    bx_scl = 0; step(STUCK - 1); bx_scl = 1; step(1);
    chk("R2 alternating lines", connect, 1); chk("R2 fault", fault, 0);
    bx_sda = 0; step(STUCK - 1); bx_sda = 1; step(1);
    bx_sda = 0; step(STUCK - 1); bx_sda = 1; step(1);
    chk("R2 split low", connect, 1);

    k = 1; base = falls; arm = 1;
    step(STUCK - 1); chk("R1 before limit", connect, 1);
    step(1);         chk("R1 drop", connect, 0); chk("R3 fault", fault, 1);
    chk("R4 first low", scl_pd, 1); chk("R4 sda idle", sda_pd, 0);
    step(H - 1);     chk("R4 low width", scl_pd, 1);
    step(1);         chk("R4 high half", scl_pd, 0);
    step(H);         chk("R6 both low scl", scl_pd, 1); chk("R6 both low sda", sda_pd, 1);
    step(H);         chk("R6 scl free", scl_pd, 0); chk("R6 sda held", sda_pd, 1);
    step(H);         chk("R6 free sda", sda_pd, 0); chk("R6 still open", connect, 0);
    step(H);         chk("R6 relink", connect, 1); chk("R7 fault held", fault, 1);
    step(1);         chk("R7 fault clear", fault, 0);
    arm = 0; step(2);

    for (int r = 0; r < 6; r++) begin
      k = VEC[r][0]; base = falls; p0 = pdrises; s0 = stops; arm = 1;
      wait_conn(0);
      chk("R3 table drop", fault, 1);
      wait_conn(1);
      chk("R5 pulses", pdrises - p0, VEC[r][1] + 1);
      chk("R6 stop seen", stops - s0, VEC[r][2]);
      arm = 0; step(2);
      chk("R7 table fault", fault, 0); chk("R7 table link", connect, 1);
    end

    disc_en = 0; k = 0; arm = 1;
    step(STUCK + 10);
    chk("R10 link kept", connect, 1); chk("R10 fault", fault, 1);
    chk("R10 no scl pd", scl_pd, 0);  chk("R10 no sda pd", sda_pd, 0);
    arm = 0; step(2); chk("R10 fault clear", fault, 0);
    disc_en = 1;

    k = 0; arm = 1; wait_conn(0); step(2);
    en = 1; arm = 0; step(1);
    chk("R9 relink", connect, 1); chk("R9 scl pd", scl_pd, 0); chk("R9 sda pd", sda_pd, 0);
    en = 0; step(2); chk("R9 fault clear", fault, 0);

    rst_n = 0; bx_sda = 0; k = 0; arm = 1; step(2);
    rst_n = 1; step(3 * IDLE); chk("R8 busy wait", connect, 0);
    bx_sda = 1; step(2);       chk("R8 one side", connect, 0);
    arm = 0; step(1);          chk("R8 stop early", connect, 0);
    step(1);                   chk("R8 stop link", connect, 1);
  endtask

  initial begin
    fork
      run_all();
      begin repeat (150000) @(posedge clk); wd = 1; end
    join_any
    disable fork;
    if (wd) begin
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule